// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a system watchdog with a small set of 16-bit registers behind a synchronous read/write port. A down-counter steps once per slow tick. The tick period is a parameter in clock cycles, and its default matches roughly 0.6 s at 125 MHz. Software keeps the system alive by writing the reload register. When the counter runs out for the first time, the block flags a timeout and may issue a one-cycle system-management interrupt pulse. The counter then restarts from the initial-count register. If it runs out a second time before any reload, the block flags a second timeout and issues a one-cycle system reset pulse, unless the no-reboot input is active. A halt bit freezes the countdown. A sticky lock bit freezes both the halt bit and the sampled no-reboot setting.

The register port has no handshake. A write is taken in the cycle that `reg_wr` is high, and it can never stall. Reads are combinational from `reg_addr`. Addresses are halfword indices, so index N is byte offset 2N. Byte lane 0 is bits 7:0 and byte lane 1 is bits 15:8. Message, data, second-control, watchdog-control and software-interrupt registers are plain storage.

Top module: `wdt_top`

## Requirements
- R1: After reset the counter and the initial-count register both read 4. Every other register reads 0, and `smi_o` and `sys_rst_o` are low.
- R2: Halfword index 1 (data), 5 and 6 (message) are 16-bit storage, and 7 and 8 are 8-bit storage in bits 7:0. A write changes only the byte lanes whose enable is set. Indices 10 to 15 read as 0.
- R3: Index 0 reads the live counter value. The counter falls by one per tick. A tick that finds it at 0 is an expiry, and that expiry loads the counter from the initial-count register at index 9.
- R4: The first expiry sets timeout bit 3 of the first status register (index 2). If the SMI enable (bit 9 of index 4) is set, it also pulses `smi_o` and sets interrupt-status bit 2 of index 2.
- R5: An expiry that follows an earlier expiry with no reload in between sets second-timeout bit 1 of index 3. Unless the sampled no-reboot is set, it also pulses `sys_rst_o` and sets boot-status bit 2 of index 3.
- R6: Any write to index 0 with a byte enabled loads the counter from index 9, clears the timeout history, and overrides a tick in the same cycle.
- R7: Writing one to bit 1 of index 3 clears the timeout history, so the next expiry is again a first expiry.
- R8: While halt bit 11 of index 4 is set, ticks do not change the counter.
- R9: Lock bit 12 of index 4 can only be set and stays set until reset. While it is set, writes cannot change the halt bit, and the sampled no-reboot stops following `no_reboot_i`.
- R10: A write stores data only in mask 0xE870 of index 2, mask 0xFFF8 of index 3 and mask 0xFEFF of index 4. Event bits 3 and 2 of index 2, and bits 1 and 2 of index 3, clear on a write of one. A setting event wins over a clear in the same cycle. All other bits are unchanged by writes.
- R11: `smi_o` and `sys_rst_o` are single-cycle pulses, registered one clock after the expiry tick.
- R12: Index 9 keeps only its low 10 bits (mask 0x3FF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register halfword index |
| reg_wr | input | 1 | Write strobe, accepted in the same cycle |
| reg_be | input | 2 | Byte-lane enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| no_reboot_i | input | 1 | Blocks the reset pulse on a second expiry |
| smi_o | output | 1 | One-cycle interrupt pulse on first expiry |
| sys_rst_o | output | 1 | One-cycle reset pulse on second expiry |

## Verification
The hardest state to reach is a locked block whose frozen no-reboot setting differs from the live pin while two expiries happen without a reload. The stimulus sets the pin, sets the lock, drops the pin, and then tries to set halt through the locked register. It then clears the timeout history and lets the counter run through both expiries, checking that no reset pulse appears and that the second-timeout flag is set. The status-clear tests are placed in the short window right after an expiry, so that status values are checked before the next tick can disturb them.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 16;

  localparam logic [3:0] AD_RLD  = 4'd0;
  localparam logic [3:0] AD_DATA = 4'd1;
  localparam logic [3:0] AD_STS1 = 4'd2;
  localparam logic [3:0] AD_STS2 = 4'd3;
  localparam logic [3:0] AD_CTL1 = 4'd4;
  localparam logic [3:0] AD_CTL2 = 4'd5;
  localparam logic [3:0] AD_MSG  = 4'd6;
  localparam logic [3:0] AD_WDC  = 4'd7;
  localparam logic [3:0] AD_SWI  = 4'd8;
  localparam logic [3:0] AD_INIT = 4'd9;

  localparam logic [DW-1:0] STS1_KEEP = 16'hE870;
  localparam logic [DW-1:0] STS2_KEEP = 16'hFFF8;
  localparam logic [DW-1:0] CTL1_KEEP = 16'hFEFF;
  localparam logic [DW-1:0] BYTE_KEEP = 16'h00FF;
  localparam logic [DW-1:0] FULL_KEEP = 16'hFFFF;

  localparam int TO1_BIT   = 3;
  localparam int INTS_BIT  = 2;
  localparam int TO2_BIT   = 1;
  localparam int BOOT_BIT  = 2;
  localparam int SMIEN_BIT = 9;
  localparam int HALT_BIT  = 11;
  localparam int LOCK_BIT  = 12;

  localparam logic [DW-1:0] STS1_W1C = 16'h000C;
  localparam logic [DW-1:0] STS2_W1C = 16'h0006;

  function automatic logic [DW-1:0] lane_bits(input logic [1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = be[i/8];
    return r;
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] nw,
                                               input logic [1:0]    be,
                                               input logic [DW-1:0] keep);
    logic [DW-1:0] sel;
    sel = lane_bits(be) & keep;
    return (cur & ~sel) | (nw & sel);
  endfunction
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int unsigned TICK_CYC = 75_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (TICK_CYC <= 1) begin : g_every
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_o <= 1'b0;
        else        tick_o <= 1'b1;
      end
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_CYC);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_CYC - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q  <= '0;
          tick_o <= 1'b0;
        end else begin
          tick_o <= (div_q == LAST);
          div_q  <= (div_q == LAST) ? '0 : div_q + DIV_W'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             smi_en,
  input  logic             nr_eff,
  input  logic             rld_wr,
  input  logic             clr_second,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_first,
  output logic             ev_second,
  output logic             smi_o,
  output logic             rst_o
);
  logic seen_q;
  logic step;
  logic expire;

  assign step      = tick && !halt && !rld_wr;
  assign expire    = step && (cnt == '0);
  assign ev_first  = expire && !seen_q;
  assign ev_second = expire && seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= CNT_W'(INIT_RST);
      seen_q <= 1'b0;
      smi_o  <= 1'b0;
      rst_o  <= 1'b0;
    end else begin
      if (rld_wr)      cnt <= init_val;
      else if (expire) cnt <= init_val;
      else if (step)   cnt <= cnt - CNT_W'(1);

      if (rld_wr)          seen_q <= 1'b0;
      else if (ev_first)   seen_q <= 1'b1;
      else if (ev_second)  seen_q <= 1'b1;
      else if (clr_second) seen_q <= 1'b0;

      smi_o <= ev_first && smi_en;
      rst_o <= ev_second && !nr_eff;
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       addr,
  input  logic             wr,
  input  logic [1:0]       be,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ev_first,
  input  logic             ev_second,
  input  logic             no_reboot_i,
  output logic             rld_wr,
  output logic             clr_second,
  output logic             halt,
  output logic             smi_en,
  output logic             lock,
  output logic             nr_eff,
  output logic             sec_sts,
  output logic [CNT_W-1:0] init_val
);
  localparam logic [DW-1:0] INIT_KEEP = DW'((1 << CNT_W) - 1);
  localparam int NSTORE = 5;
  localparam logic [3:0] STORE_AD [NSTORE] = '{AD_DATA, AD_CTL2, AD_MSG, AD_WDC, AD_SWI};
  localparam logic [DW-1:0] STORE_KEEP [NSTORE] = '{FULL_KEEP, FULL_KEEP, FULL_KEEP, BYTE_KEEP, BYTE_KEEP};

  logic [DW-1:0] sts1_q, sts2_q, ctl1_q;
  logic [DW-1:0] sts1_d, sts2_d, ctl1_d;
  logic [DW-1:0] init_q, init_d;
  logic [DW-1:0] store_q [NSTORE];
  logic [DW-1:0] lanes;
  logic          nr_q;

  assign lanes      = lane_bits(be);
  assign rld_wr     = wr && (addr == AD_RLD) && (be != 2'b00);
  assign clr_second = wr && (addr == AD_STS2) && be[0] && wdata[TO2_BIT];
  assign halt       = ctl1_q[HALT_BIT];
  assign lock       = ctl1_q[LOCK_BIT];
  assign smi_en     = ctl1_q[SMIEN_BIT];
  assign nr_eff     = nr_q;
  assign sec_sts    = sts2_q[TO2_BIT];
  assign init_val   = init_q[CNT_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < NSTORE; gi++) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q[gi] <= '0;
        else if (wr && addr == STORE_AD[gi])
          store_q[gi] <= lane_merge(store_q[gi], wdata, be, STORE_KEEP[gi]);
      end
    end
  endgenerate

  always_comb begin
    sts1_d = sts1_q;
    sts2_d = sts2_q;
    ctl1_d = ctl1_q;
    init_d = init_q;
    if (wr) begin
      unique case (addr)
        AD_STS1: sts1_d = lane_merge(sts1_q, wdata, be, STS1_KEEP) & ~(wdata & lanes & STS1_W1C);
        AD_STS2: sts2_d = lane_merge(sts2_q, wdata, be, STS2_KEEP) & ~(wdata & lanes & STS2_W1C);
        AD_CTL1: begin
          ctl1_d = lane_merge(ctl1_q, wdata, be, CTL1_KEEP);
          if (lock) ctl1_d[HALT_BIT] = ctl1_q[HALT_BIT];
          ctl1_d[LOCK_BIT] = ctl1_d[LOCK_BIT] | ctl1_q[LOCK_BIT];
        end
        AD_INIT: init_d = lane_merge(init_q, wdata, be, INIT_KEEP);
        default: ;
      endcase
    end
    if (ev_first) sts1_d[TO1_BIT] = 1'b1;
    if (ev_first && smi_en) sts1_d[INTS_BIT] = 1'b1;
    if (ev_second) sts2_d[TO2_BIT] = 1'b1;
    if (ev_second && !nr_q) sts2_d[BOOT_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts1_q <= '0;
      sts2_q <= '0;
      ctl1_q <= '0;
      init_q <= DW'(INIT_RST);
      nr_q   <= 1'b0;
    end else begin
      sts1_q <= sts1_d;
      sts2_q <= sts2_d;
      ctl1_q <= ctl1_d;
      init_q <= init_d;
      if (!lock) nr_q <= no_reboot_i;
    end
  end

  always_comb begin
    unique case (addr)
      AD_RLD:  rdata = DW'(cnt);
      AD_DATA: rdata = store_q[0];
      AD_STS1: rdata = sts1_q;
      AD_STS2: rdata = sts2_q;
      AD_CTL1: rdata = ctl1_q;
      AD_CTL2: rdata = store_q[1];
      AD_MSG:  rdata = store_q[2];
      AD_WDC:  rdata = store_q[3];
      AD_SWI:  rdata = store_q[4];
      AD_INIT: rdata = init_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int unsigned TICK_CYC = 75_000_000,
  parameter int          CNT_W    = 10,
  parameter int          INIT_RST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        no_reboot_i,
  output logic        smi_o,
  output logic        sys_rst_o
);
  logic             tick_w;
  logic             rld_wr_w, clr_second_w;
  logic             halt_w, smi_en_w, lock_w, nr_eff_w, sec_sts_w;
  logic [CNT_W-1:0] init_w, cnt_w;
  logic             ev_first_w, ev_second_w;

  wdt_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  wdt_regs #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .be(reg_be),
    .wdata(reg_wdata), .rdata(reg_rdata), .cnt(cnt_w),
    .ev_first(ev_first_w), .ev_second(ev_second_w), .no_reboot_i(no_reboot_i),
    .rld_wr(rld_wr_w), .clr_second(clr_second_w), .halt(halt_w),
    .smi_en(smi_en_w), .lock(lock_w), .nr_eff(nr_eff_w), .sec_sts(sec_sts_w),
    .init_val(init_w)
  );

  wdt_core #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .halt(halt_w), .smi_en(smi_en_w),
    .nr_eff(nr_eff_w), .rld_wr(rld_wr_w), .clr_second(clr_second_w),
    .init_val(init_w), .cnt(cnt_w), .ev_first(ev_first_w),
    .ev_second(ev_second_w), .smi_o(smi_o), .rst_o(sys_rst_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smi,
  input logic             sysrst,
  input logic             lock,
  input logic             halt,
  input logic             smi_en,
  input logic             rld,
  input logic             sec_sts,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init
);
  AST_SMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) smi |=> !smi); // R11
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sysrst |=> !sysrst); // R11
  AST_RST_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) sysrst |-> sec_sts); // R5
  AST_SMI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) smi |-> $past(smi_en)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock |=> lock); // R9
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) lock |=> $stable(halt)); // R9
  AST_HALT_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n) (halt && !rld) |=> $stable(cnt)); // R8
  AST_RLD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) rld |=> (cnt == $past(init))); // R6
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smi(smi_o), .sysrst(sys_rst_o), .lock(lock_w),
  .halt(halt_w), .smi_en(smi_en_w), .rld(rld_wr_w), .sec_sts(sec_sts_w),
  .cnt(cnt_w), .init(init_w)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  localparam int T  = 8;
  localparam int CW = 10;
  localparam int IR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        no_reboot = 1'b0;
  logic        smi_o, sys_rst_o;

  always #4 clk = ~clk;

  wdt_top #(.TICK_CYC(T), .CNT_W(CW), .INIT_RST(IR)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .no_reboot_i(no_reboot), .smi_o(smi_o), .sys_rst_o(sys_rst_o)
  );

  int total = 0;
  int bad = 0;
  int smi_seen = 0;
  int rst_seen = 0;
  string cur_req = "R1";

  int m_div, m_cnt, m_init, m_sts1, m_sts2, m_ctl1, m_ctl2, m_data, m_msg, m_wdc, m_swi;
  bit m_tick, m_tmo, m_smi, m_rst, m_nr;

  function automatic int bemask(logic [1:0] b);
    return (b[0] ? 32'h00FF : 0) | (b[1] ? 32'hFF00 : 0);
  endfunction

  function automatic int mix(int old, int nw, int m);
    return (old & ~m) | (nw & m);
  endfunction

  function automatic int m_read(logic [3:0] a);
    case (a)
      4'd0: return m_cnt;
      4'd1: return m_data;
      4'd2: return m_sts1;
      4'd3: return m_sts2;
      4'd4: return m_ctl1;
      4'd5: return m_ctl2;
      4'd6: return m_msg;
      4'd7: return m_wdc;
      4'd8: return m_swi;
      4'd9: return m_init;
      default: return 0;
    endcase
  endfunction

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    int e, wd, n1, n2, nc;
    bit rld, tk, hl, lk, se, ex, f, s, clr2;
    if (!rst_n) begin
      m_div = 0; m_tick = 0; m_cnt = IR; m_init = IR; m_tmo = 0;
      m_smi = 0; m_rst = 0; m_nr = 0;
      m_sts1 = 0; m_sts2 = 0; m_ctl1 = 0; m_ctl2 = 0;
      m_data = 0; m_msg = 0; m_wdc = 0; m_swi = 0;
    end else begin
      e    = reg_wr ? bemask(reg_be) : 0;
      wd   = int'(reg_wdata);
      rld  = reg_wr && reg_addr == 4'd0 && reg_be != 2'b00;
      clr2 = reg_wr && reg_addr == 4'd3 && reg_be[0] && reg_wdata[1];
      tk = m_tick; hl = m_ctl1[11]; lk = m_ctl1[12]; se = m_ctl1[9];
      ex = tk && !hl && !rld && m_cnt == 0;
      f  = ex && !m_tmo;
      s  = ex && m_tmo;
      m_tick = (m_div == T - 1);
      m_div  = (m_div == T - 1) ? 0 : m_div + 1;
      if (rld) m_cnt = m_init;
      else if (tk && !hl) m_cnt = (m_cnt == 0) ? m_init : m_cnt - 1;
      if (rld) m_tmo = 0;
      else if (f) m_tmo = 1;
      else if (clr2) m_tmo = 0;
      m_smi = f && se;
      m_rst = s && !m_nr;
      n1 = m_sts1; n2 = m_sts2; nc = m_ctl1;
      if (e != 0) begin
        case (reg_addr)
          4'd1: m_data = mix(m_data, wd, e);
          4'd2: n1 = mix(m_sts1, wd, e & 32'hE870) & ~(wd & e & 32'h000C);
          4'd3: n2 = mix(m_sts2, wd, e & 32'hFFF8) & ~(wd & e & 32'h0006);
          4'd4: begin
            nc = mix(m_ctl1, wd, e & 32'hFEFF);
            if (lk) nc = (nc & ~32'h0800) | (m_ctl1 & 32'h0800);
            nc = nc | (m_ctl1 & 32'h1000);
          end
          4'd5: m_ctl2 = mix(m_ctl2, wd, e);
          4'd6: m_msg  = mix(m_msg, wd, e);
          4'd7: m_wdc  = mix(m_wdc, wd, e & 32'hFF);
          4'd8: m_swi  = mix(m_swi, wd, e & 32'hFF);
          4'd9: m_init = mix(m_init, wd, e & 32'h3FF);
          default: ;
        endcase
      end
      if (f) n1 = n1 | 32'h8;
      if (f && se) n1 = n1 | 32'h4;
      if (s) n2 = n2 | 32'h2;
      if (s && !m_nr) n2 = n2 | 32'h4;
      m_sts1 = n1; m_sts2 = n2; m_ctl1 = nc;
      if (!lk) m_nr = no_reboot;
    end
  end

  // cycle compare against the model, away from the edges
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      total++;
      if (reg_rdata !== 16'(m_read(reg_addr)) || smi_o !== m_smi || sys_rst_o !== m_rst) begin
        bad++;
        $display("FAIL %s per-cycle: rdata=%h smi=%b rst=%b expected rdata=%h smi=%b rst=%b",
                 cur_req, reg_rdata, smi_o, sys_rst_o, 16'(m_read(reg_addr)), m_smi, m_rst);
      end
      if (smi_o) smi_seen++;
      if (sys_rst_o) rst_seen++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_be = b; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_pulse(bit want_rst, int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      #3;
      if ((want_rst ? sys_rst_o : smi_o) === 1'b1) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=expired expected=done");
    finish_run();
  end

  initial begin
    int v, s0, r0;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    chk("R1", "smi after reset", int'(smi_o), 0);
    chk("R1", "reset pulse after reset", int'(sys_rst_o), 0);
    rd(4'd0, v); chk("R1", "counter", v, IR);
    rd(4'd9, v); chk("R1", "init count", v, IR);
    rd(4'd2, v); chk("R1", "status1", v, 0);
    rd(4'd3, v); chk("R1", "status2", v, 0);
    rd(4'd4, v); chk("R1", "control1", v, 0);

    cur_req = "R2";
    wr(4'd1, 16'hA55A, 2'b11); rd(4'd1, v); chk("R2", "data storage", v, 16'hA55A);
    wr(4'd6, 16'h1234, 2'b01); rd(4'd6, v); chk("R2", "message low lane only", v, 16'h0034);
    wr(4'd7, 16'hBEEF, 2'b11); rd(4'd7, v); chk("R2", "8-bit storage", v, 16'h00EF);
    rd(4'd12, v); chk("R2", "unmapped read", v, 0);

    cur_req = "R12";
    wr(4'd9, 16'hFFFF, 2'b11); rd(4'd9, v); chk("R12", "init mask", v, 16'h03FF);
    wr(4'd9, 16'h0003, 2'b11);

    cur_req = "R10";
    wr(4'd4, 16'h0300, 2'b11); rd(4'd4, v); chk("R10", "control1 bit 8 kept zero", v, 16'h0200);

    cur_req = "R6";
    wr(4'd0, 16'h0000, 2'b11); rd(4'd0, v); chk("R6", "reload loads init", v, 3);
    s0 = smi_seen;
    for (int k = 0; k < 8; k++) begin
      repeat (16) @(negedge clk);
      wr(4'd0, 16'h0000, 2'b10);
    end
    chk("R6", "no expiry while reloading", smi_seen - s0, 0);

    cur_req = "R4";
    wait_pulse(0, 100, got);
    chk("R4", "smi pulse on first expiry", int'(got), 1);
    @(negedge clk); #3;
    chk("R11", "smi one cycle", int'(smi_o), 0);
    rd(4'd2, v); chk("R4", "status1 timeout+int", v, 16'h000C);
    rd(4'd0, v); chk("R3", "counter reloaded from init", v, 3);

    cur_req = "R5";
    wait_pulse(1, 100, got);
    chk("R5", "reset pulse on second expiry", int'(got), 1);
    rd(4'd3, v); chk("R5", "status2 second+boot", v, 16'h0006);

    cur_req = "R10";
    wr(4'd2, 16'hFFFF, 2'b11); rd(4'd2, v); chk("R10", "status1 mask and clear", v, 16'hE870);
    wr(4'd3, 16'hFFFF, 2'b10); rd(4'd3, v); chk("R10", "status2 high lane only", v, 16'hFF06);
    cur_req = "R7";
    wr(4'd3, 16'h0006, 2'b01); rd(4'd3, v); chk("R10", "status2 event clear", v, 16'hFF00);
    r0 = rst_seen;
    wait_pulse(0, 100, got);
    chk("R7", "next expiry is first again", int'(got), 1);
    rd(4'd3, v); chk("R7", "no second timeout", v, 16'hFF00);
    rd(4'd2, v); chk("R7", "status1 flagged", v, 16'hE87C);
    chk("R7", "no reset pulse", rst_seen - r0, 0);

    cur_req = "R5";
    no_reboot = 1'b1;
    wr(4'd0, 16'h0000, 2'b11);
    r0 = rst_seen;
    wait_pulse(0, 100, got);
    repeat (40) @(negedge clk);
    chk("R5", "no-reboot blocks reset", rst_seen - r0, 0);
    rd(4'd3, v); chk("R5", "second flagged without boot", v, 16'hFF02);

    cur_req = "R8";
    wr(4'd4, 16'h0A00, 2'b11);
    rd(4'd0, s0);
    repeat (40) @(negedge clk);
    rd(4'd0, v); chk("R8", "halt holds counter", v, s0);
    wr(4'd4, 16'h0200, 2'b11);

    cur_req = "R9";
    wr(4'd4, 16'h1200, 2'b11);
    no_reboot = 1'b0;
    wr(4'd4, 16'h0A00, 2'b11);
    rd(4'd4, v); chk("R9", "lock sticky and halt frozen", v, 16'h1200);
    wr(4'd3, 16'h0002, 2'b01);
    wr(4'd0, 16'h0000, 2'b11);
    s0 = smi_seen; r0 = rst_seen;
    repeat (100) @(negedge clk);
    chk("R9", "counter still runs", int'(smi_seen > s0), 1);
    chk("R9", "frozen no-reboot blocks reset", rst_seen - r0, 0);
    rd(4'd3, v); chk("R9", "second timeout flagged", v & 16'h0006, 16'h0002);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule